// File: doc/BRIEF.md
# Shared GPIO Port Level Resolver

This block owns a bidirectional general-purpose port of `PINS` lines that two parties may drive at once: the CPU through a small word-addressed register bus, and a group of attached peripheral agents that present one combined direction word and one combined data word. Each pin also has an optional pull-up. The block resolves the level on every pin from these sources and returns the resolved levels, not the stored CPU value, whenever software reads the data register.

Each CPU write to the data or control register is compared against the pin levels just before that write. The XOR of the old and new levels forms a change mask. Each of up to `SLOTS` agent slots holds its own trigger mask. An occupied slot whose trigger mask overlaps the change mask gets a one-cycle notify strobe. The port-interrupt enable register exists only to catch software that tries to turn port interrupts on: any nonzero value written to it raises an error pulse.

Top module: `gpio_share_port`

## Requirements
- R1: After reset the control, data, interrupt-enable and all trigger-mask registers read 0. The pins resolve to 0. `change_o`, `notify_o` and `ien_err_o` are 0.
- R2: Register words are: 0 = control, 1 = data, 2 = interrupt enable, 3+i = trigger mask of slot i. In the control word, bit 2n enables the CPU driver of pin n and bit 2n+1 enables its pull-up. Written registers read back their value, except the data word (see R4).
- R3: Pin n resolves to (cpu_dir & cpu_data) | (per_dir & per_data) | (~(cpu_dir | per_dir) & pull_up). `pin_lvl_o` shows this continuously.
- R4: A read of word 1 returns the resolved pin levels, zero-extended, rather than the stored CPU data.
- R5: After a write to word 0 or word 1, `change_o` holds old_levels XOR new_levels for exactly the following cycle. The old levels are taken just before the write and the new levels just after it.
- R6: A data or control write that leaves every pin level unchanged produces a zero change mask and no notify strobe.
- R7: In the cycle after a data or control write, `notify_o[i]` is 1 only when `slot_present_i[i]` is 1 and the slot-i trigger mask ANDed with the change mask is nonzero. Otherwise it is 0. The strobe lasts one cycle.
- R8: Writing a nonzero value to word 2 sets `ien_err_o` high for the next cycle. A zero write does not.
- R9: Writes to any other register, and changes on the peripheral inputs, produce no change mask and no notify strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW (3) | Register word address |
| bus_wdata_i | input | DW (32) | Write data |
| bus_rdata_o | output | DW (32) | Read data, combinational |
| per_dir_i | input | PINS (16) | Combined peripheral driver enables |
| per_dat_i | input | PINS (16) | Combined peripheral drive values |
| slot_present_i | input | SLOTS (4) | Agent slot occupied flags |
| pin_lvl_o | output | PINS (16) | Resolved pin levels |
| change_o | output | PINS (16) | Change mask, valid the cycle after a port write |
| notify_o | output | SLOTS (4) | Per-slot notify strobes |
| ien_err_o | output | 1 | Error pulse for a nonzero interrupt-enable write |

## Verification
The assertions check four things on every cycle:
- Notify strobes and change masks appear only in the cycle after a port write.
- A zero change mask never comes with a strobe.
- An unoccupied slot is never strobed.
- Data-word reads return the resolved levels, and the error pulse follows exactly the nonzero interrupt-enable writes.

The bench's scenarios cover what a single-cycle property cannot:
- The resolution formula under mixed CPU, peripheral and pull-up sources.
- The bit-pair control encoding.
- The exact content of the change mask after control writes as well as data writes.
- Which slots a given mask overlap selects.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int CTRL_OFS = 0;
  localparam int DATA_OFS = 1;
  localparam int IEN_OFS  = 2;
  localparam int MASK_OFS = 3;
endpackage

// File: rtl/gpio_ctrl_split.sv
module gpio_ctrl_split #(
  parameter int PINS = 16,
  localparam int CW = 2 * PINS
) (
  input  logic [CW-1:0]   ctrl_i,
  output logic [PINS-1:0] dir_o,
  output logic [PINS-1:0] pull_o
);
  for (genvar n = 0; n < PINS; n++) begin : g_pin
    assign dir_o[n]  = ctrl_i[2*n];
    assign pull_o[n] = ctrl_i[2*n+1];
  end
endmodule

// File: rtl/gpio_level_resolve.sv
module gpio_level_resolve #(
  parameter int PINS = 16
) (
  input  logic [PINS-1:0] cpu_dir_i,
  input  logic [PINS-1:0] cpu_dat_i,
  input  logic [PINS-1:0] per_dir_i,
  input  logic [PINS-1:0] per_dat_i,
  input  logic [PINS-1:0] pull_i,
  output logic [PINS-1:0] lvl_o
);
  always_comb begin
    lvl_o = (cpu_dir_i & cpu_dat_i)
          | (per_dir_i & per_dat_i)
          | (~(cpu_dir_i | per_dir_i) & pull_i);
  end
endmodule

// File: rtl/gpio_notify_gen.sv
module gpio_notify_gen #(
  parameter int PINS  = 16,
  parameter int SLOTS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fire_i,
  input  logic [PINS-1:0]       old_i,
  input  logic [PINS-1:0]       new_i,
  input  logic [SLOTS*PINS-1:0] mask_i,
  input  logic [SLOTS-1:0]      present_i,
  output logic [PINS-1:0]       change_o,
  output logic [SLOTS-1:0]      notify_o
);
  logic [PINS-1:0]  diff;
  logic [SLOTS-1:0] hit;

  assign diff = old_i ^ new_i;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign hit[s] = present_i[s] && |(mask_i[s*PINS +: PINS] & diff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      change_o <= '0;
      notify_o <= '0;
    end else if (fire_i) begin
      change_o <= diff;
      notify_o <= hit;
    end else begin
      change_o <= '0;
      notify_o <= '0;
    end
  end

  p_quiet_without_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> (notify_o == '0 && change_o == '0));
  p_no_change_no_notify_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (change_o == '0) |-> (notify_o == '0));
  p_only_occupied_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> ((notify_o & ~$past(present_i)) == '0));
endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port
  import gpio_pkg::*;
#(
  parameter int PINS  = 16,
  parameter int SLOTS = 4,
  parameter int AW    = 3,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic [PINS-1:0]  per_dir_i,
  input  logic [PINS-1:0]  per_dat_i,
  input  logic [SLOTS-1:0] slot_present_i,
  output logic [PINS-1:0]  pin_lvl_o,
  output logic [PINS-1:0]  change_o,
  output logic [SLOTS-1:0] notify_o,
  output logic             ien_err_o
);
  localparam int CW = 2 * PINS;
  localparam logic [AW-1:0] A_CTRL = AW'(CTRL_OFS);
  localparam logic [AW-1:0] A_DATA = AW'(DATA_OFS);
  localparam logic [AW-1:0] A_IEN  = AW'(IEN_OFS);

  logic [CW-1:0]         ctrl_q, ctrl_nxt;
  logic [PINS-1:0]       dat_q, dat_nxt;
  logic [PINS-1:0]       ien_q;
  logic [SLOTS*PINS-1:0] mask_q;
  logic                  err_q;

  logic wr, wr_ctrl, wr_data, wr_ien, fire;
  logic [SLOTS-1:0] wr_mask;

  assign wr      = bus_req_i && bus_we_i;
  assign wr_ctrl = wr && (bus_addr_i == A_CTRL);
  assign wr_data = wr && (bus_addr_i == A_DATA);
  assign wr_ien  = wr && (bus_addr_i == A_IEN);
  assign fire    = wr_ctrl || wr_data;

  assign ctrl_nxt = wr_ctrl ? bus_wdata_i[CW-1:0] : ctrl_q;
  assign dat_nxt  = wr_data ? bus_wdata_i[PINS-1:0] : dat_q;

  // current and post-write views of the port
  logic [PINS-1:0] dir_cur, pull_cur, dir_nxt, pull_nxt, lvl_cur, lvl_nxt;

  gpio_ctrl_split #(.PINS(PINS)) u_split_cur (
    .ctrl_i(ctrl_q), .dir_o(dir_cur), .pull_o(pull_cur));
  gpio_ctrl_split #(.PINS(PINS)) u_split_nxt (
    .ctrl_i(ctrl_nxt), .dir_o(dir_nxt), .pull_o(pull_nxt));

  gpio_level_resolve #(.PINS(PINS)) u_res_cur (
    .cpu_dir_i(dir_cur), .cpu_dat_i(dat_q), .per_dir_i(per_dir_i),
    .per_dat_i(per_dat_i), .pull_i(pull_cur), .lvl_o(lvl_cur));
  gpio_level_resolve #(.PINS(PINS)) u_res_nxt (
    .cpu_dir_i(dir_nxt), .cpu_dat_i(dat_nxt), .per_dir_i(per_dir_i),
    .per_dat_i(per_dat_i), .pull_i(pull_nxt), .lvl_o(lvl_nxt));

  gpio_notify_gen #(.PINS(PINS), .SLOTS(SLOTS)) u_notify (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .old_i(lvl_cur),
    .new_i(lvl_nxt), .mask_i(mask_q), .present_i(slot_present_i),
    .change_o(change_o), .notify_o(notify_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      dat_q  <= '0;
      ien_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_nxt;
      dat_q  <= dat_nxt;
      if (wr_ien) ien_q <= bus_wdata_i[PINS-1:0];
      err_q  <= wr_ien && (bus_wdata_i[PINS-1:0] != '0);
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_mask
    assign wr_mask[s] = wr && (bus_addr_i == AW'(MASK_OFS + s));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         mask_q[s*PINS +: PINS] <= '0;
      else if (wr_mask[s]) mask_q[s*PINS +: PINS] <= bus_wdata_i[PINS-1:0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_CTRL)      bus_rdata_o = DW'(ctrl_q);
    else if (bus_addr_i == A_DATA) bus_rdata_o = DW'(lvl_cur);
    else if (bus_addr_i == A_IEN)  bus_rdata_o = DW'(ien_q);
    for (int s = 0; s < SLOTS; s++)
      if (bus_addr_i == AW'(MASK_OFS + s)) bus_rdata_o = DW'(mask_q[s*PINS +: PINS]);
  end

  assign pin_lvl_o = lvl_cur;
  assign ien_err_o = err_q;

  p_read_levels_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_addr_i == A_DATA) |-> (bus_rdata_o == DW'(pin_lvl_o)));
  p_err_on_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ien && bus_wdata_i[PINS-1:0] != '0) |=> ien_err_o);
  p_err_only_on_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ien |=> !ien_err_o);
endmodule

// File: tb/gpio_share_port_tb.sv
module gpio_share_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:0] pdir = '0, pdat = '0, lvl, chg;
  logic [3:0]  present = '0, notify;
  logic        err;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gpio_share_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .per_dir_i(pdir), .per_dat_i(pdat), .slot_present_i(present),
    .pin_lvl_o(lvl), .change_o(chg), .notify_o(notify), .ien_err_o(err));

  // {ctrl, cpu data, per dir, per data, expected levels}
  localparam logic [95:0] VECS [0:6] = '{
    {32'h0000_0000, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000},
    {32'h5555_5555, 16'hA5A5, 16'h0000, 16'h0000, 16'hA5A5},
    {32'hAAAA_AAAA, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF},
    {32'hAAAA_AAAA, 16'h0000, 16'h00FF, 16'h0F0F, 16'hFF0F},
    {32'h0000_0003, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {32'h0000_000E, 16'h0002, 16'h0000, 16'h0000, 16'h0003},
    {32'h5555_0000, 16'h1234, 16'h0F0F, 16'h0300, 16'h1300}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic done();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done();
  end

  initial begin
    logic [31:0] r;
    #9 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 pins", 32'(lvl), 0);
    chk("R1 notify", 32'(notify), 0);
    chk("R1 change", 32'(chg), 0);
    chk("R1 err", 32'(err), 0);
    rd(3'd0, r); chk("R1 ctrl", r, 0);
    rd(3'd3, r); chk("R1 mask0", r, 0);

    // R2/R3/R4 table walk
    for (int i = 0; i < 7; i++) begin
      wr(3'd0, VECS[i][95:64]);
      wr(3'd1, 32'(VECS[i][63:48]));
      @(negedge clk);
      pdir = VECS[i][47:32];
      pdat = VECS[i][31:16];
      rd(3'd1, r);
      chk("R4 data read levels", r, 32'(VECS[i][15:0]));
      chk("R3 pin levels", 32'(lvl), 32'(VECS[i][15:0]));
    end
    rd(3'd0, r); chk("R2 ctrl readback", r, 32'h5555_0000);

    // notification setup
    @(negedge clk); pdir = '0; pdat = '0; present = 4'b1011;
    wr(3'd0, 32'h5555_5555);
    wr(3'd1, 32'h0);
    wr(3'd3, 32'h0001);
    wr(3'd4, 32'hFF00);
    wr(3'd5, 32'h0002);
    wr(3'd6, 32'hFFFF);
    chk("R9 mask write change", 32'(chg), 0);
    chk("R9 mask write notify", 32'(notify), 0);
    rd(3'd4, r); chk("R2 mask1 readback", r, 32'hFF00);

    wr(3'd1, 32'h0003);
    chk("R5 data change", 32'(chg), 32'h0003);
    chk("R7 data notify", 32'(notify), 32'b1001);
    @(negedge clk);
    chk("R7 pulse width", 32'(notify), 0);
    chk("R5 change cleared", 32'(chg), 0);

    wr(3'd1, 32'h0003);
    chk("R6 same data change", 32'(chg), 0);
    chk("R6 same data notify", 32'(notify), 0);

    wr(3'd0, 32'h0);
    chk("R5 ctrl change", 32'(chg), 32'h0003);
    chk("R7 ctrl notify", 32'(notify), 32'b1001);

    wr(3'd0, 32'hAAAA_AAAA);
    chk("R5 pullup change", 32'(chg), 32'hFFFF);
    chk("R7 slot2 absent", 32'(notify), 32'b1011);

    @(negedge clk); pdir = 16'hFFFF; pdat = 16'h0000;
    @(negedge clk);
    chk("R3 peripheral overrides pull", 32'(lvl), 0);
    chk("R9 input change notify", 32'(notify), 0);
    chk("R9 input change mask", 32'(chg), 0);

    wr(3'd2, 32'h0004);
    chk("R8 nonzero ien err", 32'(err), 1);
    chk("R9 ien write notify", 32'(notify), 0);
    @(negedge clk);
    chk("R8 err pulse", 32'(err), 0);
    wr(3'd2, 32'h0);
    chk("R8 zero ien no err", 32'(err), 0);

    done();
  end
endmodule